// File: doc/BRIEF.md
# Chained-descriptor scatter-gather read DMA

This block moves data out of host memory by following a singly linked list of descriptors. Each descriptor names one buffer: its start address, its length in bytes, and the address of the descriptor after it. Software writes the address of the first descriptor into a register pair and then writes a start bit. From then on the engine needs no help. It reads the descriptor, reads the buffer one 32-bit word at a time through a request/response memory port, and hands each word to a valid/ready stream. It then follows the link to the next descriptor. A link value of zero ends the list.

The engine raises its interrupt only once for the whole list, after the last word of the last buffer has left on the stream. Software can therefore queue many buffers behind a single start and take a single interrupt for all of them. The interrupt is a level. It is gated by an enable bit and stays up until software clears the done flag.

Top module: `sg_dma_engine`

## Requirements
- R1: After reset, the status register reads 0, `irq` is low, and neither `mem_req_valid` nor `st_valid` is asserted.
- R2: A descriptor is five 32-bit words at consecutive word addresses, read in order. Word 0 is the buffer address bits 31:0, word 1 is the buffer address bits 63:32, word 2 is the length in bytes, word 3 is the link bits 31:0 and word 4 is the link bits 63:32. All five words are read before the buffer is touched, and every memory request address has its two low bits at zero.
- R3: A buffer of L bytes (0 < L <= 4096) is sent as ceil(L/4) words taken from ascending word addresses. Each word is passed unchanged, and `st_last` is high on the final word of each buffer.
- R4: A length field above 4096 is treated as 4096, which gives 1024 words.
- R5: A descriptor with length 0 causes no buffer reads and no stream words. The engine goes straight on to its link.
- R6: A link with all 64 bits at zero ends the list. Any other link value makes the engine fetch a further descriptor at that address.
- R7: The busy bit (status bit 0) reads 1 from the start write until completion. A start write made while busy has no effect on the transfer in progress.
- R8: The done bit (status bit 1) is set only after the last stream word has been accepted, at the same moment busy falls. `irq` equals done AND irq_enable (control bit 1). Writing status with bit 1 set clears done.
- R9: A memory request holds its address, and a stream word holds its data and `st_last`, until the matching ready is seen.
- R10: Memory requests are issued only while busy. At most one read is outstanding at a time, so a chain of D descriptors carrying W words makes exactly 5*D + W requests.
- R11: Register select 0 and 1 hold bits 31:0 and 63:32 of the first-descriptor address (read/write). Select 2 is control: writing bit 0 = 1 starts the engine, and bit 1 is irq_enable. Select 3 is status. Reads are combinational from `reg_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_sel` |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_addr | output | 64 | Byte address of requested word |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| st_valid | output | 1 | Stream word valid |
| st_ready | input | 1 | Stream sink ready |
| st_data | output | 32 | Stream word |
| st_last | output | 1 | Final word of a buffer |
| irq | output | 1 | Chain-complete interrupt level |

## Verification
Almost any fault in the walker shows up at the ports within a few words. A descriptor word landing in the wrong field sends reads to the wrong addresses, so the streamed data stops matching the expected pattern. A miscounted length changes the number of words, moves `st_last`, or changes the total request count checked when the chain finishes. A bad end-of-chain decision either hangs the engine, which the done poll catches, or makes it stop early. Early completion appears as done rising while expected words are still queued. An ignored start that is in fact honoured changes the data stream straight away.

// File: rtl/sgdma_pkg.sv
package sgdma_pkg;

  typedef enum logic [2:0] {
    W_IDLE,
    W_FETCH,
    W_SEG,
    W_CHECK,
    W_DONE
  } walk_state_t;

  localparam int DESC_WORDS = 5;

  localparam logic [1:0] SEL_PTR_LO = 2'd0;
  localparam logic [1:0] SEL_PTR_HI = 2'd1;
  localparam logic [1:0] SEL_CTRL   = 2'd2;
  localparam logic [1:0] SEL_STAT   = 2'd3;

endpackage

// File: rtl/sgdma_regs.sv
module sgdma_regs
  import sgdma_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [1:0]  reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        busy,
  input  logic        done_evt,
  output logic [63:0] first_ptr,
  output logic        start,
  output logic        irq_en,
  output logic        done_flag,
  output logic        irq
);

  logic [63:0] first_q, first_d;
  logic        ien_q, ien_d;
  logic        done_q, done_d;
  logic        ptr_en, ien_en, done_en;

  always_comb begin
    first_d = first_q;
    ptr_en  = 1'b0;
    ien_d   = ien_q;
    ien_en  = 1'b0;
    done_d  = done_q;
    done_en = 1'b0;
    if (reg_we && reg_sel == SEL_PTR_LO) begin
      first_d[31:0] = reg_wdata;
      ptr_en = 1'b1;
    end
    if (reg_we && reg_sel == SEL_PTR_HI) begin
      first_d[63:32] = reg_wdata;
      ptr_en = 1'b1;
    end
    if (reg_we && reg_sel == SEL_CTRL) begin
      ien_d  = reg_wdata[1];
      ien_en = 1'b1;
    end
    if (done_evt) begin
      done_d  = 1'b1;
      done_en = 1'b1;
    end else if (reg_we && reg_sel == SEL_STAT && reg_wdata[1]) begin
      done_d  = 1'b0;
      done_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= '0;
      ien_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      if (ptr_en)  first_q <= first_d;
      if (ien_en)  ien_q   <= ien_d;
      if (done_en) done_q  <= done_d;
    end
  end

  always_comb begin
    case (reg_sel)
      SEL_PTR_LO: reg_rdata = first_q[31:0];
      SEL_PTR_HI: reg_rdata = first_q[63:32];
      SEL_CTRL:   reg_rdata = {30'd0, ien_q, 1'b0};
      default:    reg_rdata = {30'd0, done_q, busy};
    endcase
  end

  assign start     = reg_we && (reg_sel == SEL_CTRL) && reg_wdata[0] && !busy;
  assign first_ptr = first_q;
  assign irq_en    = ien_q;
  assign done_flag = done_q;
  assign irq       = done_q & ien_q;

endmodule

// File: rtl/sgdma_walker.sv
module sgdma_walker
  import sgdma_pkg::*;
#(
  parameter int MAX_SEG_BYTES = 4096
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [63:0] first_ptr,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic [63:0] mem_req_addr,
  input  logic        mem_rsp_valid,
  input  logic [31:0] mem_rsp_data,
  input  logic        buf_full,
  output logic        buf_load,
  output logic        buf_last,
  output logic        busy,
  output logic        done_evt
);

  localparam int MAX_WORDS = MAX_SEG_BYTES / 4;
  localparam int CNT_W     = $clog2(MAX_WORDS + 1);
  localparam int IDX_W     = $clog2(DESC_WORDS);

  walk_state_t      state_q, state_d;
  logic [63:2]      desc_q, desc_d;
  logic [IDX_W-1:0] widx_q, widx_d;
  logic             pend_q, pend_d;
  logic [63:2]      seg_q, seg_d;
  logic [CNT_W-1:0] left_q, left_d;
  logic [63:0]      next_q, next_d;
  logic             req_fire, rsp_fire;
  logic [CNT_W-1:0] len_words;

  // Byte length to word count, with the segment limit applied.
  always_comb begin
    if (mem_rsp_data > 32'(MAX_SEG_BYTES))
      len_words = CNT_W'(MAX_WORDS);
    else
      len_words = CNT_W'(({1'b0, mem_rsp_data} + 33'd3) >> 2);
  end

  assign mem_req_valid = !pend_q &&
                         ((state_q == W_FETCH) || (state_q == W_SEG && !buf_full));
  assign mem_req_addr  = (state_q == W_FETCH) ? {desc_q + 62'(widx_q), 2'b00}
                                              : {seg_q, 2'b00};
  assign req_fire      = mem_req_valid && mem_req_ready;
  assign rsp_fire      = mem_rsp_valid && pend_q;
  assign buf_load      = rsp_fire && (state_q == W_SEG);
  assign buf_last      = (left_q == CNT_W'(1));
  assign busy          = (state_q != W_IDLE);
  assign done_evt      = (state_q == W_DONE);

  always_comb begin
    state_d = state_q;
    desc_d  = desc_q;
    widx_d  = widx_q;
    pend_d  = pend_q;
    seg_d   = seg_q;
    left_d  = left_q;
    next_d  = next_q;
    case (state_q)
      W_IDLE: begin
        if (start) begin
          desc_d  = first_ptr[63:2];
          widx_d  = '0;
          pend_d  = 1'b0;
          state_d = W_FETCH;
        end
      end
      W_FETCH: begin
        if (req_fire) pend_d = 1'b1;
        if (rsp_fire) begin
          pend_d = 1'b0;
          widx_d = widx_q + IDX_W'(1);
          case (widx_q)
            IDX_W'(0): seg_d[31:2]   = mem_rsp_data[31:2];
            IDX_W'(1): seg_d[63:32]  = mem_rsp_data;
            IDX_W'(2): left_d        = len_words;
            IDX_W'(3): next_d[31:0]  = mem_rsp_data;
            IDX_W'(4): begin
              next_d[63:32] = mem_rsp_data;
              state_d = (left_q == '0) ? W_CHECK : W_SEG;
            end
            default: ;
          endcase
        end
      end
      W_SEG: begin
        if (req_fire) begin
          pend_d = 1'b1;
          seg_d  = seg_q + 62'd1;
        end
        if (rsp_fire) begin
          pend_d = 1'b0;
          left_d = left_q - CNT_W'(1);
          if (left_q == CNT_W'(1)) state_d = W_CHECK;
        end
      end
      W_CHECK: begin
        if (next_q != '0) begin
          desc_d  = next_q[63:2];
          widx_d  = '0;
          state_d = W_FETCH;
        end else if (!buf_full) begin
          state_d = W_DONE;
        end
      end
      W_DONE:  state_d = W_IDLE;
      default: state_d = W_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= W_IDLE;
      desc_q  <= '0;
      widx_q  <= '0;
      pend_q  <= 1'b0;
      seg_q   <= '0;
      left_q  <= '0;
      next_q  <= '0;
    end else begin
      state_q <= state_d;
      desc_q  <= desc_d;
      widx_q  <= widx_d;
      pend_q  <= pend_d;
      seg_q   <= seg_d;
      left_q  <= left_d;
      next_q  <= next_d;
    end
  end

endmodule

// File: rtl/sgdma_outbuf.sv
module sgdma_outbuf #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              load_last,
  output logic              full,
  output logic              st_valid,
  input  logic              st_ready,
  output logic [DATA_W-1:0] st_data,
  output logic              st_last
);

  logic              full_q, full_d, full_en;
  logic [DATA_W-1:0] data_q;
  logic              last_q;

  always_comb begin
    full_d  = full_q;
    full_en = 1'b0;
    if (load) begin
      full_d  = 1'b1;
      full_en = 1'b1;
    end else if (full_q && st_ready) begin
      full_d  = 1'b0;
      full_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
      last_q <= 1'b0;
    end else begin
      if (full_en) full_q <= full_d;
      if (load) begin
        data_q <= load_data;
        last_q <= load_last;
      end
    end
  end

  assign full     = full_q;
  assign st_valid = full_q;
  assign st_data  = data_q;
  assign st_last  = last_q;

endmodule

// File: rtl/sg_dma_engine.sv
module sg_dma_engine
  import sgdma_pkg::*;
#(
  parameter int MAX_SEG_BYTES = 4096
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [1:0]  reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic [63:0] mem_req_addr,
  input  logic        mem_rsp_valid,
  input  logic [31:0] mem_rsp_data,
  output logic        st_valid,
  input  logic        st_ready,
  output logic [31:0] st_data,
  output logic        st_last,
  output logic        irq
);

  logic [1:0]  rst_pipe;
  logic        rst_sync_n;
  logic        busy, done_evt, done_flag, irq_en, start;
  logic [63:0] first_ptr;
  logic        buf_full, buf_load, buf_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  sgdma_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .reg_we    (reg_we),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .busy      (busy),
    .done_evt  (done_evt),
    .first_ptr (first_ptr),
    .start     (start),
    .irq_en    (irq_en),
    .done_flag (done_flag),
    .irq       (irq)
  );

  sgdma_walker #(.MAX_SEG_BYTES(MAX_SEG_BYTES)) u_walk (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .start         (start),
    .first_ptr     (first_ptr),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .buf_full      (buf_full),
    .buf_load      (buf_load),
    .buf_last      (buf_last),
    .busy          (busy),
    .done_evt      (done_evt)
  );

  sgdma_outbuf #(.DATA_W(32)) u_obuf (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .load      (buf_load),
    .load_data (mem_rsp_data),
    .load_last (buf_last),
    .full      (buf_full),
    .st_valid  (st_valid),
    .st_ready  (st_ready),
    .st_data   (st_data),
    .st_last   (st_last)
  );

endmodule

// File: rtl/sgdma_chk.sv
module sgdma_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic [63:0] mem_req_addr,
  input logic        mem_rsp_valid,
  input logic        st_valid,
  input logic        st_ready,
  input logic [31:0] st_data,
  input logic        st_last,
  input logic        busy,
  input logic        done_flag,
  input logic        irq_en,
  input logic        irq
);

  logic [1:0] outst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) outst <= 2'd0;
    else if (mem_req_valid && mem_req_ready) outst <= outst + 2'd1;
    else if (mem_rsp_valid && outst != 2'd0) outst <= outst - 2'd1;
  end

  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  assert_stream_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid && !st_ready |=> st_valid && $stable(st_data) && $stable(st_last));

  assert_req_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> busy);

  assert_single_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> outst == 2'd0);

  assert_word_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_req_addr[1:0] == 2'b00);

  assert_irq_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> irq_en && done_flag);

  assert_done_drained_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_flag) |-> !st_valid && !busy);

  assert_stream_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |-> busy);

endmodule

bind sg_dma_engine sgdma_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_sync_n),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .mem_rsp_valid (mem_rsp_valid),
  .st_valid      (st_valid),
  .st_ready      (st_ready),
  .st_data       (st_data),
  .st_last       (st_last),
  .busy          (busy),
  .done_flag     (done_flag),
  .irq_en        (irq_en),
  .irq           (irq)
);

// File: tb/tb_sg_dma_engine.sv
module tb_sg_dma_engine;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [63:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        st_valid;
  logic        st_ready = 1'b0;
  logic [31:0] st_data;
  logic        st_last;
  logic        irq;

  sg_dma_engine dut (.*);

  always #10 clk = ~clk;

  int nchk = 0;
  int nfail = 0;
  int cyc = 0;
  int rdy_pct = 100;
  int reqcnt = 0;
  logic [31:0] desc_mem [256];
  logic [32:0] expq [$];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pattern(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  function automatic logic [31:0] mem_word(input logic [63:0] a);
    if (a[31:10] == 0) return desc_mem[a[9:2]];
    return pattern(a[31:0]);
  endfunction

  // memory model: one read at a time, random latency
  bit pend = 0;
  int dly = 0;
  logic [63:0] paddr;
  always @(negedge clk) begin
    mem_rsp_valid = 1'b0;
    if (!rst_n) begin
      mem_req_ready = 1'b0;
      pend = 0;
    end else if (pend) begin
      mem_req_ready = 1'b0;
      if (dly == 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = mem_word(paddr);
        pend = 0;
      end else dly--;
    end else begin
      mem_req_ready = ($urandom % 4) != 0;
      if (mem_req_valid && mem_req_ready) begin
        pend  = 1;
        paddr = mem_req_addr;
        dly   = $urandom % 3;
        reqcnt++;
        if (mem_req_addr[63:32] != 32'h1) begin
          nchk++; nfail++;
          $display("FAIL R2 request high word actual=%0h expected=1", mem_req_addr[63:32]);
        end
      end
    end
  end

  // stream sink and comparator
  always @(negedge clk) begin
    if (!rst_n) st_ready = 1'b0;
    else begin
      st_ready = ($urandom % 100) < rdy_pct;
      if (st_valid && st_ready) begin
        if (expq.size() == 0) begin
          chk(1'b0, "R3 unexpected stream word", {st_last, st_data}, 0);
        end else begin
          logic [32:0] e;
          e = expq.pop_front();
          chk({st_last, st_data} == e, "R3 stream word/last", {st_last, st_data}, e);
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] d);
    @(negedge clk);
    reg_sel = sel;
    #1 d = reg_rdata;
  endtask

  // Writes one descriptor; returns its request cost (5 + words).
  task automatic add_desc(input int slot, input int seg_word, input logic [31:0] len,
                          input int nxt, input bit expect_it, inout int cost);
    int base = slot * 5;
    logic [31:0] seg = 32'(seg_word * 4);
    int clen = (len > 4096) ? 4096 : int'(len);
    int nw = (clen + 3) / 4;
    desc_mem[base]     = seg;
    desc_mem[base + 1] = 32'h1;
    desc_mem[base + 2] = len;
    desc_mem[base + 3] = (nxt < 0) ? 32'h0 : 32'(nxt * 20);
    desc_mem[base + 4] = (nxt < 0) ? 32'h0 : 32'h1;
    if (expect_it) begin
      for (int i = 0; i < nw; i++)
        expq.push_back({(i == nw - 1), pattern(seg + 32'(i * 4))});
      cost += 5 + nw;
    end
  endtask

  task automatic run_chain(input int slot, input bit ien, input int exp_req,
                           input int intrude_slot, input string tag);
    logic [31:0] s;
    int t;
    reqcnt = 0;
    wr(2'd0, 32'(slot * 20));
    wr(2'd1, 32'h1);
    wr(2'd2, {30'd0, ien, 1'b1});
    rd(2'd3, s);
    chk(s[0] == 1'b1, {"R7 busy after start ", tag}, s[0], 1);
    if (intrude_slot >= 0) begin
      wr(2'd0, 32'(intrude_slot * 20));
      wr(2'd2, {30'd0, ien, 1'b1});
      rd(2'd3, s);
      chk(s[0] == 1'b1, {"R7 still busy after ignored start ", tag}, s[0], 1);
    end
    t = 0;
    do begin
      rd(2'd3, s);
      t++;
    end while (!s[1] && t < 60000);
    chk(s[1] == 1'b1, {"R8 done reached ", tag}, s[1], 1);
    chk(s[0] == 1'b0, {"R7 busy clear at done ", tag}, s[0], 0);
    chk(expq.size() == 0, {"R8 all words out before done ", tag}, expq.size(), 0);
    chk(reqcnt == exp_req, {"R10 request count ", tag}, reqcnt, exp_req);
    chk(irq == ien, {"R8 irq follows enable ", tag}, irq, ien);
    if (!ien) begin
      wr(2'd2, 32'h2);
      #1 chk(irq == 1'b1, {"R8 irq after enabling ", tag}, irq, 1);
    end
    wr(2'd3, 32'h2);
    rd(2'd3, s);
    chk(s[1] == 1'b0, {"R8 done cleared by write-one ", tag}, s[1], 0);
    chk(irq == 1'b0, {"R8 irq cleared ", tag}, irq, 0);
    expq.delete();
  endtask

  initial begin
    logic [31:0] v;
    int cost;
    void'($urandom(32'h5EED));
    for (int i = 0; i < 256; i++) desc_mem[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(2'd3, v);
    chk(v == 32'd0, "R1 status after reset", v, 0);
    chk(irq == 1'b0, "R1 irq after reset", irq, 0);
    chk(!mem_req_valid && !st_valid, "R1 no traffic after reset", {mem_req_valid, st_valid}, 0);
    // R11 pointer registers read back
    wr(2'd0, 32'hDEAD_BEE4);
    wr(2'd1, 32'h0000_0001);
    rd(2'd0, v); chk(v == 32'hDEAD_BEE4, "R11 pointer low readback", v, 32'hDEAD_BEE4);
    rd(2'd1, v); chk(v == 32'h1, "R11 pointer high readback", v, 1);
    rd(2'd3, v); chk(v[0] == 1'b0, "R11 pointer write does not start", v, 0);

    // R2/R3 single descriptor, 8 bytes
    cost = 0; add_desc(0, 300, 8, -1, 1, cost);
    run_chain(0, 1, cost, -1, "single");

    // R3/R6 three descriptors with unaligned lengths 5, 1, 12
    cost = 0;
    add_desc(2, 400, 5, 5, 1, cost);
    add_desc(5, 500, 1, 7, 1, cost);
    add_desc(7, 600, 12, -1, 1, cost);
    rdy_pct = 50;
    run_chain(2, 1, cost, -1, "three-link");

    // R5 zero-length in the middle, and a chain of one empty descriptor
    cost = 0;
    add_desc(1, 700, 8, 3, 1, cost);
    add_desc(3, 800, 0, 4, 1, cost);
    add_desc(4, 900, 4, -1, 1, cost);
    run_chain(1, 1, cost, -1, "R5 zero-middle");
    cost = 0; add_desc(9, 1000, 0, -1, 1, cost);
    run_chain(9, 1, cost, -1, "R5 empty-only");

    // R4 clamp of oversize length
    cost = 0; add_desc(10, 1024, 5000, -1, 1, cost);
    rdy_pct = 70;
    run_chain(10, 1, cost, -1, "R4 clamp");

    // R7 start while busy ignored
    cost = 0;
    add_desc(12, 1200, 64, -1, 1, cost);
    begin
      int dummy = 0;
      add_desc(14, 2200, 40, -1, 0, dummy);
    end
    run_chain(12, 1, cost, 14, "R7 intrude");

    // R8 interrupt masked, then enabled
    cost = 0; add_desc(16, 2600, 16, -1, 1, cost);
    run_chain(16, 0, cost, -1, "R8 masked");

    // random chains
    for (int k = 0; k < 12; k++) begin
      int n = 1 + ($urandom % 4);
      cost = 0;
      for (int d = 0; d < n; d++) begin
        int len = (($urandom % 5) == 0) ? 0 : int'($urandom % 80);
        add_desc(20 + d * 3, 256 + int'($urandom % 3000), 32'(len),
                 (d == n - 1) ? -1 : 20 + (d + 1) * 3, 1, cost);
      end
      rdy_pct = 40 + int'($urandom % 61);
      run_chain(20, bit'($urandom % 2), cost, -1, "R6 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule